// File: doc/BRIEF.md
# PPM to Control-Word Encoder

This block turns a requested frequency offset, given in parts per million as a signed fixed-point number, into the two's-complement control word that steers a digitally tuned oscillator. It also produces the two 16-bit register payloads that a frame serialiser downstream sends to the oscillator. The caller picks one of seven pull ranges and one of two resolution modes. A coarse mode makes a 16-bit word that fits in one register. A fine mode makes a 23-bit word that is split across an upper register and a lower register.

A request is taken when `req_valid_i` is high while `req_ready_o` is high. The magnitude of the request is multiplied by a fixed-point scale factor that depends on both the range and the mode. A shift-add unit does this one bit per cycle. The product is then rounded to the nearest integer, saturated at the limits of the word, given back its sign and split into payloads. All results are registered together with a one-cycle `done_o` pulse and hold their value until the next pulse.

Top module: `ppm_ctrl_encoder`

## Requirements
- R1: `req_ready_o` is high when idle. A request is taken when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is low from the cycle after acceptance until the cycle of `done_o`. `done_o` pulses for exactly one cycle per accepted request, and `req_ready_o` is high in that cycle.
- R2: `req_ppm_i` is signed with 16 fractional bits. The code is round(|ppm| x K / 2^32), with ties rounded up in magnitude, and it carries the sign of the request. K = round((2^(N-1)-1) x 2^16 / (PR x 1.00135625)), where N is 16 in coarse mode and 23 in fine mode.
- R3: Range select codes 0 to 6 pick PR = 25 x 2^code ppm (25, 50, 100, 200, 400, 800, 1600). Code 7 gives the same results as code 6.
- R4: Coarse mode (`req_mode_i`=0): the code is a 16-bit two's-complement value. `code_o` is that value sign-extended to 23 bits. `hi_payload_o` = code[15:0] and `lo_payload_o` = 0.
- R5: Fine mode (`req_mode_i`=1): the code is a 23-bit two's-complement value. `hi_payload_o` = code[22:7] and `lo_payload_o` = {9'b0, code[6:0]}.
- R6: Requests of opposite sign and equal magnitude give codes of equal magnitude and opposite sign, unless they saturate.
- R7: A positive request whose rounded magnitude exceeds 2^(N-1)-1 gives the most positive code (0x7FFF, or 0x3FFFFF in fine mode). A negative request whose rounded magnitude exceeds 2^(N-1) gives the most negative code. In both cases `sat_o` is 1; otherwise `sat_o` is 0.
- R8: Outputs change only in the `done_o` cycle. A request offered while `req_ready_o` is low is ignored: it changes no result and produces no `done_o`.
- R9: After reset `req_ready_o`=1, `done_o`=0, and `code_o`, both payloads and `sat_o` are 0.
- R10: In fine mode at range code 6, +245.6 ppm gives 0x09CF8A with payloads 0x139F and 0x000A. -831.2 ppm gives 0x5ECC0B with payloads 0xBD98 and 0x000B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ppm_i | input | 32 | Signed offset in ppm, 16 fractional bits |
| req_range_i | input | 3 | Pull range select |
| req_mode_i | input | 1 | 0 = 16-bit word, 1 = 23-bit word |
| req_ready_o | output | 1 | Ready to accept a request |
| done_o | output | 1 | One-cycle result strobe |
| code_o | output | 23 | Signed control word, sign-extended in coarse mode |
| hi_payload_o | output | 16 | Payload for the upper register |
| lo_payload_o | output | 16 | Payload for the lower register |
| sat_o | output | 1 | Request was clamped |

## Verification
The bench builds the block with its package defaults: a 32-bit request with 16 fractional bits, scale factors with 16 fractional bits and seven ranges. With these values, requests of up to about 32768 ppm reach the multiplier at full width. That makes saturation reachable at every range in both modes, and it lets the 23-bit fine-mode code and its 16/7 split be checked against exact integer products. Random offsets are drawn to about 1.2 times the chosen range, so each run covers both clamped and in-range codes.

// File: rtl/ppm_enc_pkg.sv
package ppm_enc_pkg;
  localparam int PPM_W      = 32;
  localparam int PPM_FRAC   = 16;
  localparam int K_FRAC     = 16;
  localparam int NUM_RANGES = 7;
  localparam int RSEL_W     = $clog2(NUM_RANGES + 1);
  localparam int PR_BASE    = 25;
  localparam int CODE_W1    = 16;
  localparam int CODE_W2    = 23;
  localparam int PAY_W      = 16;
  localparam int LO_BITS    = CODE_W2 - PAY_W;
  // PR_BASE >= 2^4, so the integer part of K fits in CODE_W2-1-4 bits
  localparam int K_W        = CODE_W2 - 1 - 4 + K_FRAC;
  localparam int PROD_W     = PPM_W + K_W;
  localparam int SHIFT      = PPM_FRAC + K_FRAC;
  localparam int RND_W      = PROD_W + 1 - SHIFT;

  localparam logic [127:0] TRIM_NUM = 128'd100135625;
  localparam logic [127:0] TRIM_DEN = 128'd100000000;

  function automatic logic [K_W-1:0] k_calc(input int fine, input int rsel);
    logic [127:0] num, den, q;
    int n;
    n   = (fine != 0) ? CODE_W2 : CODE_W1;
    num = (((128'd1 << (n - 1)) - 128'd1) << K_FRAC) * TRIM_DEN;
    den = (128'(PR_BASE) << rsel) * TRIM_NUM;
    q   = (num + (den >> 1)) / den;
    return q[K_W-1:0];
  endfunction
endpackage

// File: rtl/ppm_scale_table.sv
module ppm_scale_table
  import ppm_enc_pkg::*;
(
  input  logic [RSEL_W-1:0] range_i,
  input  logic              mode_i,
  output logic [K_W-1:0]    k_o
);
  logic [K_W-1:0]    tab [2][NUM_RANGES];
  logic [RSEL_W-1:0] idx;

  for (genvar m = 0; m < 2; m++) begin : g_mode
    for (genvar r = 0; r < NUM_RANGES; r++) begin : g_rng
      assign tab[m][r] = k_calc(m, r);
    end
  end

  // out-of-table codes fall back to the widest range
  assign idx = (range_i >= RSEL_W'(NUM_RANGES)) ? RSEL_W'(NUM_RANGES - 1) : range_i;
  assign k_o = tab[mode_i][idx];
endmodule

// File: rtl/ppm_shift_mult.sv
module ppm_shift_mult #(
  parameter int A_W = 32,
  parameter int B_W = 34
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [A_W-1:0]     a_i,
  input  logic [B_W-1:0]     b_i,
  output logic               done_o,
  output logic [A_W+B_W-1:0] prod_o
);
  localparam int P_W   = A_W + B_W;
  localparam int CNT_W = $clog2(A_W + 1);

  logic [A_W-1:0]   a_q;
  logic [P_W-1:0]   b_q, acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      a_q    <= a_i;
      b_q    <= P_W'(b_i);
      acc_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      if (a_q[0]) acc_q <= acc_q + b_q;
      a_q   <= a_q >> 1;
      b_q   <= b_q << 1;
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == CNT_W'(A_W - 1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign prod_o = acc_q;
endmodule

// File: rtl/ppm_code_pack.sv
module ppm_code_pack
  import ppm_enc_pkg::*;
(
  input  logic [PROD_W-1:0]  prod_i,
  input  logic               neg_i,
  input  logic               mode_i,
  output logic [CODE_W2-1:0] code_o,
  output logic [PAY_W-1:0]   hi_o,
  output logic [PAY_W-1:0]   lo_o,
  output logic               sat_o
);
  logic [PROD_W:0]      rnd_full;
  logic [RND_W-1:0]     mag_r, lim;
  logic [CODE_W2-1:0]   mag_c;
  logic [RND_W-1:0]     half_w1, half_w2;

  assign half_w1 = RND_W'(1) << (CODE_W1 - 1);
  assign half_w2 = RND_W'(1) << (CODE_W2 - 1);

  always_comb begin
    // round half away from zero on the magnitude
    rnd_full = {1'b0, prod_i} + ((PROD_W+1)'(1) << (SHIFT - 1));
    mag_r    = rnd_full[PROD_W:SHIFT];
    if (mode_i) lim = neg_i ? half_w2 : half_w2 - RND_W'(1);
    else        lim = neg_i ? half_w1 : half_w1 - RND_W'(1);
    sat_o  = mag_r > lim;
    mag_c  = sat_o ? lim[CODE_W2-1:0] : mag_r[CODE_W2-1:0];
    code_o = neg_i ? (~mag_c + CODE_W2'(1)) : mag_c;
    if (mode_i) begin
      hi_o = code_o[CODE_W2-1:LO_BITS];
      lo_o = {{(PAY_W-LO_BITS){1'b0}}, code_o[LO_BITS-1:0]};
    end else begin
      hi_o = code_o[CODE_W1-1:0];
      lo_o = '0;
    end
  end
endmodule

// File: rtl/ppm_ctrl_encoder.sv
module ppm_ctrl_encoder
  import ppm_enc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [PPM_W-1:0]   req_ppm_i,
  input  logic [RSEL_W-1:0]  req_range_i,
  input  logic               req_mode_i,
  output logic               req_ready_o,
  output logic               done_o,
  output logic [CODE_W2-1:0] code_o,
  output logic [PAY_W-1:0]   hi_payload_o,
  output logic [PAY_W-1:0]   lo_payload_o,
  output logic               sat_o
);
  logic               busy_q, neg_q, mode_q, done_q, sat_q;
  logic               accept, mult_done;
  logic [PPM_W-1:0]   mag;
  logic [K_W-1:0]     k_sel;
  logic [PROD_W-1:0]  prod;
  logic [CODE_W2-1:0] code_d, code_q;
  logic [PAY_W-1:0]   hi_d, lo_d, hi_q, lo_q;
  logic               sat_d;

  assign accept = req_valid_i && !busy_q;
  assign mag    = req_ppm_i[PPM_W-1] ? (~req_ppm_i + PPM_W'(1)) : req_ppm_i;

  ppm_scale_table u_table (
    .range_i (req_range_i),
    .mode_i  (req_mode_i),
    .k_o     (k_sel)
  );

  ppm_shift_mult #(.A_W(PPM_W), .B_W(K_W)) u_mult (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .a_i     (mag),
    .b_i     (k_sel),
    .done_o  (mult_done),
    .prod_o  (prod)
  );

  ppm_code_pack u_pack (
    .prod_i (prod),
    .neg_i  (neg_q),
    .mode_i (mode_q),
    .code_o (code_d),
    .hi_o   (hi_d),
    .lo_o   (lo_d),
    .sat_o  (sat_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      neg_q  <= 1'b0;
      mode_q <= 1'b0;
      done_q <= 1'b0;
      code_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
      sat_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        neg_q  <= req_ppm_i[PPM_W-1];
        mode_q <= req_mode_i;
      end else if (mult_done) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        code_q <= code_d;
        hi_q   <= hi_d;
        lo_q   <= lo_d;
        sat_q  <= sat_d;
      end
    end
  end

  assign req_ready_o  = !busy_q;
  assign done_o       = done_q;
  assign code_o       = code_q;
  assign hi_payload_o = hi_q;
  assign lo_payload_o = lo_q;
  assign sat_o        = sat_q;
endmodule

// File: rtl/ppm_ctrl_encoder_chk.sv
module ppm_ctrl_encoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        done_o,
  input logic        mode_q,
  input logic [22:0] code_o,
  input logic [15:0] hi_payload_o,
  input logic [15:0] lo_payload_o,
  input logic        sat_o
);
  p_busy_after_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  p_single_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_ready_at_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> req_ready_o);

  p_coarse_layout_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !mode_q |-> lo_payload_o == 16'h0 && hi_payload_o == code_o[15:0]
      && (code_o[22:15] == 8'h00 || code_o[22:15] == 8'hFF));

  p_fine_layout_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && mode_q |-> hi_payload_o == code_o[22:7]
      && lo_payload_o == {9'h0, code_o[6:0]});

  p_sat_extreme_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && sat_o |-> hi_payload_o == 16'h7FFF || hi_payload_o == 16'h8000);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(code_o) && $stable(hi_payload_o) && $stable(lo_payload_o)
      && $stable(sat_o));
endmodule

bind ppm_ctrl_encoder ppm_ctrl_encoder_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .done_o       (done_o),
  .mode_q       (mode_q),
  .code_o       (code_o),
  .hi_payload_o (hi_payload_o),
  .lo_payload_o (lo_payload_o),
  .sat_o        (sat_o)
);

// File: tb/ppm_ctrl_encoder_bench.sv
module ppm_ctrl_encoder_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_ppm_i = '0;
  logic [2:0]  req_range_i = '0;
  logic        req_mode_i = 1'b0;
  logic        req_ready_o, done_o, sat_o;
  logic [22:0] code_o;
  logic [15:0] hi_payload_o, lo_payload_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [22:0] last_code;

  always #2 clk = ~clk;

  ppm_ctrl_encoder u_ppm_ctrl_encoder (
    .clk_i (clk), .rst_ni (rst_ni), .req_valid_i (req_valid_i), .req_ppm_i (req_ppm_i),
    .req_range_i (req_range_i), .req_mode_i (req_mode_i), .req_ready_o (req_ready_o),
    .done_o (done_o), .code_o (code_o), .hi_payload_o (hi_payload_o),
    .lo_payload_o (lo_payload_o), .sat_o (sat_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected values straight from R2..R5, R7
  task automatic model(input longint ppm, input int r, input bit fine,
                       output logic [22:0] code, output logic [15:0] hi,
                       output logic [15:0] lo, output bit sat);
    logic [127:0] num, den, k, mag, m, lim;
    logic [22:0] c;
    int n, rr;
    n   = fine ? 23 : 16;
    rr  = (r > 6) ? 6 : r;
    num = (((128'd1 << (n - 1)) - 128'd1) << 16) * 128'd100000000;
    den = (128'd25 << rr) * 128'd100135625;
    k   = (num + den / 2) / den;
    mag = (ppm < 0) ? 128'(-ppm) : 128'(ppm);
    m   = (mag * k + (128'd1 << 31)) >> 32;
    lim = (ppm < 0) ? (128'd1 << (n - 1)) : ((128'd1 << (n - 1)) - 128'd1);
    sat = m > lim;
    if (sat) m = lim;
    c    = m[22:0];
    code = (ppm < 0) ? (~c + 23'd1) : c;
    hi   = fine ? code[22:7] : code[15:0];
    lo   = fine ? {9'h0, code[6:0]} : 16'h0;
  endtask

  task automatic run(input longint ppm, input int r, input bit fine, input string req);
    logic [22:0] ec;
    logic [15:0] eh, el;
    bit es;
    int waited;
    model(ppm, r, fine, ec, eh, el, es);
    @(negedge clk);
    check(req_ready_o == 1'b1, "R1", "ready before request", 64'(req_ready_o), 64'd1);
    req_valid_i = 1'b1;
    req_ppm_i   = ppm[31:0];
    req_range_i = r[2:0];
    req_mode_i  = fine;
    @(negedge clk);
    req_valid_i = 1'b0;
    check(req_ready_o == 1'b0, "R1", "ready after accept", 64'(req_ready_o), 64'd0);
    waited = 0;
    while (!done_o && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    check(done_o == 1'b1, "R1", "done seen", 64'(done_o), 64'd1);
    check(code_o == ec, req, "code", 64'(code_o), 64'(ec));
    check(hi_payload_o == eh, req, "hi payload", 64'(hi_payload_o), 64'(eh));
    check(lo_payload_o == el, req, "lo payload", 64'(lo_payload_o), 64'(el));
    check(sat_o == es, "R7", "sat flag", 64'(sat_o), 64'(es));
    last_code = code_o;
    @(negedge clk);
    check(done_o == 1'b0, "R1", "done single pulse", 64'(done_o), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [22:0] c_pos, c_r6;
    int dones;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(req_ready_o == 1'b1 && done_o == 1'b0, "R9", "ready/done", {req_ready_o, done_o}, 2'b10);
    check(code_o == 0 && hi_payload_o == 0 && lo_payload_o == 0 && sat_o == 0, "R9",
          "outputs zero", 64'(code_o), 64'd0);

    // R10 worked examples
    run(64'sd16095642, 6, 1'b1, "R10");
    check(code_o == 23'h09CF8A && hi_payload_o == 16'h139F && lo_payload_o == 16'h000A,
          "R10", "+245.6 ppm", {code_o, hi_payload_o, lo_payload_o}, {23'h09CF8A, 16'h139F, 16'h000A});
    run(-64'sd54473523, 6, 1'b1, "R10");
    check(code_o == 23'h5ECC0B && hi_payload_o == 16'hBD98 && lo_payload_o == 16'h000B,
          "R10", "-831.2 ppm", {code_o, hi_payload_o, lo_payload_o}, {23'h5ECC0B, 16'hBD98, 16'h000B});

    // R2 zero and R4 coarse mode
    run(0, 3, 1'b0, "R2");
    run(64'sd100 * 65536 + 12345, 4, 1'b0, "R4");
    run(-64'sd100 * 65536 - 12345, 4, 1'b0, "R4");

    // R6 symmetry
    run(64'sd13 * 65536 + 777, 2, 1'b1, "R6");
    c_pos = last_code;
    run(-64'sd13 * 65536 - 777, 2, 1'b1, "R6");
    check(last_code == ~c_pos + 23'd1, "R6", "negated code", 64'(last_code), 64'(~c_pos + 23'd1));

    // R7 saturation at both ends, both modes
    run(64'sd26 * 65536, 0, 1'b1, "R7");
    check(code_o == 23'h3FFFFF, "R7", "fine positive clamp", 64'(code_o), 64'h3FFFFF);
    run(64'sd25 * 65536, 0, 1'b1, "R7");
    run(-64'sd1700 * 65536, 6, 1'b0, "R7");
    check(hi_payload_o == 16'h8000, "R7", "coarse negative clamp", 64'(hi_payload_o), 64'h8000);
    run(-64'sd32768 * 65536, 0, 1'b1, "R7");
    run(64'sd32767 * 65536, 0, 1'b0, "R7");

    // R3 range code 7 behaves as 6
    run(64'sd500 * 65536 + 4321, 6, 1'b1, "R3");
    c_r6 = last_code;
    run(64'sd500 * 65536 + 4321, 7, 1'b1, "R3");
    check(last_code == c_r6, "R3", "code 7 vs 6", 64'(last_code), 64'(c_r6));

    // R8 request while busy is ignored
    @(negedge clk);
    req_valid_i = 1'b1; req_ppm_i = 32'(64'sd40 * 65536); req_range_i = 3'd1; req_mode_i = 1'b1;
    @(negedge clk);
    req_ppm_i = 32'(-64'sd7 * 65536); req_range_i = 3'd5; req_mode_i = 1'b0;
    repeat (5) @(negedge clk);
    req_valid_i = 1'b0;
    while (!done_o) @(negedge clk);
    begin
      logic [22:0] ec; logic [15:0] eh, el; bit es;
      model(64'sd40 * 65536, 1, 1'b1, ec, eh, el, es);
      check(code_o == ec, "R8", "busy request ignored", 64'(code_o), 64'(ec));
    end
    dones = 0;
    repeat (60) begin
      @(negedge clk);
      if (done_o) dones++;
    end
    check(dones == 0, "R8", "no extra done", 64'(dones), 64'd0);

    // random mix, R5 and R2
    for (int i = 0; i < 200; i++) begin
      int r;
      bit fine;
      longint span, p;
      r    = int'($urandom % 8);
      fine = 1'($urandom);
      span = (longint'(25) << ((r > 6) ? 6 : r)) * 65536 * 12 / 10;
      p    = longint'($urandom) % (2 * span + 1) - span;
      run(p, r, fine, fine ? "R5" : "R2");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule